// File: doc/BRIEF.md
# Digital Phase-Frequency Comparator with Qualified Lock Flag

This block compares two edge streams, a divided reference and a divided oscillator feedback. Both are sampled on a fast system clock. It measures how many clock cycles separate each pair of rising edges. When the separation is larger than a programmable window, the block drives a coarse correction pulse in the direction that pulls the loop back. When the separation is inside the window, the coarse output floats. A three-state pad is modelled by a drive-high enable, a drive-low enable and a float flag.

The same window comparison feeds a lock qualifier. The lock pull-down enable asserts only after a programmable number of back-to-back comparisons have landed inside the window. It drops on the first comparison that lands outside. The intended use is as the digital front end of a synthesizer loop, ahead of an external charge pump and filter.

Top module: `pfd_lock_top`

## Requirements
- R1: A synchronous active-high reset clears any pending edge and the consecutive-hit count. In the cycle after reset is sampled, `lock_pull`, `drv_high` and `drv_low` are 0 and `float_out` is 1.
- R2: `drv_high` and `drv_low` are never both 1. `float_out` is 1 exactly when neither of them is 1.
- R3: A rising edge is an input that is 1 in a cycle after being 0 in the previous cycle. Suppose a reference edge appears in cycle t0 and the next feedback edge appears in cycle t1, with error E = t1 - t0 greater than `win_cycles`. Then `drv_low` is 1 in cycles t0+win_cycles+1 through t1, which is E - win_cycles cycles, and `drv_high` stays 0.
- R4: When the feedback edge leads the reference edge by E cycles, with E greater than `win_cycles`, `drv_high` is 1 for E - win_cycles cycles. This pulse ends in the cycle of the reference edge, and `drv_low` stays 0.
- R5: When E is not greater than `win_cycles`, both drive enables stay 0 and `float_out` stays 1 for the whole measurement. This includes the case where both edges arrive in the same cycle (E = 0).
- R6: Each completed edge pair is one comparison. Let N be `lock_count`, with 0 treated as 1. `lock_pull` becomes 1 in the cycle after the comparison that completes N consecutive in-window comparisons. It then stays 1 while later comparisons remain in the window.
- R7: An out-of-window comparison sets `lock_pull` to 0 in the following cycle and restarts the consecutive count from zero.
- R8: Further rising edges on the leading stream, before the other stream's edge arrives, are ignored. The error is still measured from the first leading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Divided reference level, synchronous to clk |
| vco_in | input | 1 | Divided feedback level, synchronous to clk |
| win_cycles | input | ERR_W (10) | Lock window in clock cycles |
| lock_count | input | QUAL_W (4) | Consecutive in-window comparisons needed for lock |
| drv_high | output | 1 | Coarse output drives high (feedback leads) |
| drv_low | output | 1 | Coarse output drives low (reference leads) |
| float_out | output | 1 | Coarse output is high impedance |
| lock_pull | output | 1 | Lock pin pulled low when 1, released when 0 |

## Verification
The hardest situation to reach is the lock boundary. The loop must already hold lock, and then an error exactly one cycle beyond the window must arrive. The same run must also hit an error sitting exactly on the window edge. The stimulus places edge pairs at chosen cycle offsets and walks a sequence of errors: zero, inside, exactly on the window, just outside, and far outside. It covers both leading directions, and it repeats the leading edge to show that the extra edge does not shift the measurement. A reference model in the bench tracks the consecutive-hit count so that the expected lock level is known before each pair starts.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    parameter int unsigned ERR_W  = 10;
    parameter int unsigned QUAL_W = 4;

    typedef enum logic [1:0] {
        LEAD_NONE = 2'd0,
        LEAD_REF  = 2'd1,
        LEAD_VCO  = 2'd2
    } lead_e;

    typedef struct packed {
        logic             valid;
        logic             in_win;
        logic [ERR_W-1:0] err;
    } cmp_t;

    function automatic logic [ERR_W-1:0] err_step(input logic [ERR_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic logic [QUAL_W-1:0] hit_step(input logic [QUAL_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lvl,
    output logic [LANES-1:0] rise
);
    logic [LANES-1:0] prev_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b1;
            else     prev_q[g] <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev_q[g];
    end

endmodule

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
    import pfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    input  logic             vco_rise,
    input  logic [ERR_W-1:0] win,
    output logic             pulse_low,
    output logic             pulse_high,
    output cmp_t             cmp
);
    lead_e            lead_q;
    logic [ERR_W-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_q    <= LEAD_NONE;
            elapsed_q <= '0;
        end else begin
            unique case (lead_q)
                LEAD_NONE: begin
                    if (ref_rise && !vco_rise) begin
                        lead_q    <= LEAD_REF;
                        elapsed_q <= {{(ERR_W-1){1'b0}}, 1'b1};
                    end else if (vco_rise && !ref_rise) begin
                        lead_q    <= LEAD_VCO;
                        elapsed_q <= {{(ERR_W-1){1'b0}}, 1'b1};
                    end
                end
                LEAD_REF: begin
                    if (vco_rise) begin
                        lead_q    <= LEAD_NONE;
                        elapsed_q <= '0;
                    end else begin
                        elapsed_q <= err_step(elapsed_q);
                    end
                end
                LEAD_VCO: begin
                    if (ref_rise) begin
                        lead_q    <= LEAD_NONE;
                        elapsed_q <= '0;
                    end else begin
                        elapsed_q <= err_step(elapsed_q);
                    end
                end
                default: begin
                    lead_q    <= LEAD_NONE;
                    elapsed_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        cmp.valid  = ((lead_q == LEAD_NONE) && ref_rise && vco_rise) ||
                     ((lead_q == LEAD_REF)  && vco_rise) ||
                     ((lead_q == LEAD_VCO)  && ref_rise);
        cmp.err    = (lead_q == LEAD_NONE) ? '0 : elapsed_q;
        cmp.in_win = (cmp.err <= win);
    end

    assign pulse_low  = (lead_q == LEAD_REF) && (elapsed_q > win);
    assign pulse_high = (lead_q == LEAD_VCO) && (elapsed_q > win);

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmp_t              cmp,
    input  logic [QUAL_W-1:0] need,
    output logic              locked
);
    logic [QUAL_W-1:0] hits_q;
    logic [QUAL_W-1:0] hits_nxt;
    logic [QUAL_W-1:0] target;

    assign target   = (need == '0) ? {{(QUAL_W-1){1'b0}}, 1'b1} : need;
    assign hits_nxt = hit_step(hits_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hits_q <= '0;
            locked <= 1'b0;
        end else if (cmp.valid) begin
            if (cmp.in_win) begin
                hits_q <= hits_nxt;
                locked <= locked | (hits_nxt >= target);
            end else begin
                hits_q <= '0;
                locked <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              vco_in,
    input  logic [ERR_W-1:0]  win_cycles,
    input  logic [QUAL_W-1:0] lock_count,
    output logic              drv_high,
    output logic              drv_low,
    output logic              float_out,
    output logic              lock_pull
);
    localparam int unsigned LANES = 2;

    logic [LANES-1:0] rise;
    cmp_t             cmp_w;
    logic             cmp_valid;
    logic             cmp_in_win;

    pfd_edge_det #(.LANES(LANES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({vco_in, ref_in}),
        .rise (rise)
    );

    pfd_phase_core u_core (
        .clk        (clk),
        .rst        (rst),
        .ref_rise   (rise[0]),
        .vco_rise   (rise[1]),
        .win        (win_cycles),
        .pulse_low  (drv_low),
        .pulse_high (drv_high),
        .cmp        (cmp_w)
    );

    pfd_lock_qual u_qual (
        .clk    (clk),
        .rst    (rst),
        .cmp    (cmp_w),
        .need   (lock_count),
        .locked (lock_pull)
    );

    assign cmp_valid  = cmp_w.valid;
    assign cmp_in_win = cmp_w.in_win;
    assign float_out  = ~(drv_high | drv_low);

endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
    input logic clk,
    input logic rst,
    input logic ref_in,
    input logic vco_in,
    input logic drv_high,
    input logic drv_low,
    input logic lock_pull,
    input logic cmp_valid,
    input logic cmp_in_win
);
    AST_RESET_RELEASES: assert property (@(posedge clk)
        $past(rst) |-> (!lock_pull && !drv_high && !drv_low)); // R1

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(drv_high && drv_low)); // R2

    AST_LOW_ENDS_ON_VCO: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_low) |-> ($past(vco_in) || $past(rst))); // R3

    AST_HIGH_ENDS_ON_REF: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_high) |-> ($past(ref_in) || $past(rst))); // R4

    AST_LOCK_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_pull) |-> $past(cmp_valid && cmp_in_win)); // R6

    AST_LOCK_DROP_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_pull) |-> ($past(cmp_valid && !cmp_in_win) || $past(rst))); // R7

endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_in     (ref_in),
    .vco_in     (vco_in),
    .drv_high   (drv_high),
    .drv_low    (drv_low),
    .lock_pull  (lock_pull),
    .cmp_valid  (cmp_valid),
    .cmp_in_win (cmp_in_win)
);

// File: tb/sim_pfd_lock_top.sv
module sim_pfd_lock_top;
    import pfd_pkg::*;

    typedef struct {
        int    up_w;
        int    dn_w;
        int    lk;
        string tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst;
    logic              ref_in;
    logic              vco_in;
    logic [ERR_W-1:0]  win_cycles;
    logic [QUAL_W-1:0] lock_count;
    logic              drv_high, drv_low, float_out, lock_pull;

    int    n_chk = 0;
    int    n_bad = 0;
    int    upc = 0;
    int    dnc = 0;
    bit    glitch = 0;
    int    streak = 0;
    item_t q[$];

    always #10 clk = ~clk;

    pfd_lock_top u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .vco_in(vco_in),
        .win_cycles(win_cycles), .lock_count(lock_count),
        .drv_high(drv_high), .drv_low(drv_low),
        .float_out(float_out), .lock_pull(lock_pull)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: accumulates drive cycles, compares on each expected item
    initial begin
        forever begin
            @(negedge clk);
            if (drv_high) upc++;
            if (drv_low)  dnc++;
            if ((drv_high && drv_low) || (float_out == (drv_high | drv_low))) glitch = 1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, "drv_high cycles", upc, it.up_w);
                chk(it.tag, "drv_low cycles", dnc, it.dn_w);
                chk(it.tag, "lock_pull", int'(lock_pull), it.lk);
                chk("R2", "exclusive/float", int'(glitch), 0);
                upc = 0; dnc = 0; glitch = 0;
            end
        end
    end

    // driver: one edge pair; d>0 reference leads by d, d<0 feedback leads
    task automatic run_pair(int d, bit dup, string tag);
        int a, rs, vs, tgt;
        bit inw;
        item_t it;
        a  = (d < 0) ? -d : d;
        rs = (d >= 0) ? 0 : a;
        vs = (d >= 0) ? a : 0;
        for (int i = 0; i < a + 6; i++) begin
            @(posedge clk); #1;
            ref_in = (i == rs) || (i == rs + 1) ||
                     (dup && d > 0 && (i == rs + 3 || i == rs + 4));
            vco_in = (i == vs) || (i == vs + 1) ||
                     (dup && d < 0 && (i == vs + 3 || i == vs + 4));
        end
        repeat (3) begin @(posedge clk); #1; end
        inw = (a <= int'(win_cycles));
        tgt = (lock_count == 0) ? 1 : int'(lock_count);
        it.up_w = (d < 0 && !inw) ? a - int'(win_cycles) : 0;
        it.dn_w = (d > 0 && !inw) ? a - int'(win_cycles) : 0;
        if (inw) begin
            streak++;
            it.lk = (streak >= tgt) ? 1 : 0;
        end else begin
            streak = 0;
            it.lk = 0;
        end
        it.tag = tag;
        q.push_back(it);
        repeat (2) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset(string tag);
        item_t it;
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) begin @(posedge clk); #1; end
        rst = 1'b0;
        streak = 0;
        it.up_w = 0; it.dn_w = 0; it.lk = 0; it.tag = tag;
        q.push_back(it);
        repeat (2) begin @(posedge clk); #1; end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; ref_in = 1'b0; vco_in = 1'b0;
        win_cycles = 10'd4; lock_count = 4'd3;
        repeat (3) begin @(posedge clk); #1; end
        rst = 1'b0;
        // R1: state right after reset
        begin
            item_t it;
            it.up_w = 0; it.dn_w = 0; it.lk = 0; it.tag = "R1";
            q.push_back(it);
            repeat (2) begin @(posedge clk); #1; end
        end
        run_pair(0,  0, "R5");   // simultaneous
        run_pair(2,  0, "R5");
        run_pair(-4, 0, "R6");   // on window edge, third hit -> lock
        run_pair(5,  0, "R7");   // one beyond window: drop lock, 1-cycle low pulse (R3)
        run_pair(-9, 0, "R4");   // feedback far ahead
        run_pair(3,  0, "R5");
        run_pair(1,  0, "R5");
        run_pair(-2, 0, "R6");   // lock again
        run_pair(4,  0, "R6");   // stays locked
        run_pair(12, 0, "R3");   // long low pulse, drops lock
        run_pair(7,  1, "R8");   // repeated reference edge
        run_pair(-7, 1, "R8");   // repeated feedback edge
        run_pair(1,  0, "R6");
        run_pair(0,  0, "R6");
        run_pair(-1, 0, "R6");   // locked
        do_reset("R1");          // reset while locked
        lock_count = 4'd0;
        run_pair(3,  0, "R6");   // zero count acts as one
        win_cycles = 10'd0;
        run_pair(1,  0, "R3");   // zero window: any lag drives
        run_pair(-3, 0, "R4");
        run_pair(0,  0, "R5");
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule